// File: doc/BRIEF.md
# Split-Order Line Address Generator

This block produces the memory address sequence for a single-line video buffer. The buffer is read and rewritten at the same location on every pixel. Each line's pixels are stored in the order in which the previous line's addresses were visited. The visiting order changes from line to line so that the buffer can be read in an interleaved order, with the first half of the line and the second half alternating. The buffer therefore never holds more than one line.

The sequence comes from one accumulator and one pixel counter. A per-line stride is added to the accumulator at each step, and the sum is folded back by the last index whenever it passes it. The stride used for a line is the address that the previous line reached just after its midpoint. On the first line after reset, and after any change of line length, the stride is 1, so the order is plain sequential. The per-pixel path is only two parallel adders, one comparator and a select. The terms that depend only on the stride and the last index are prepared between lines.

A line begins with a one-cycle start strobe while the block is idle. After that, each clock cycle with the advance input high consumes the presented address. Exactly last-index-plus-one addresses are presented, and then the block goes idle.

Top module: `perm_line_addr`

## Requirements
- R1: After reset, `addr_vld_o` is low and stays low until a line is started with `line_go_i`.
- R2: When `line_go_i` is high while the block is idle, the next cycle shows `addr_vld_o` high and `addr_o` equal to 0. The value of `last_idx_i` sampled on that edge (L) fixes the line.
- R3: On each accepted address a (`addr_vld_o` and `step_i` both high) that is not the final one, the next address is a+S when a+S is at most L, and a+S-L otherwise, where S is the line's stride.
- R4: The final address of every line is L. Exactly L+1 addresses are accepted per line, and `addr_vld_o` falls in the cycle after the final address is accepted.
- R5: The first line after reset, and any line whose L differs from the previous line's L, uses stride 1, giving the sequence 0,1,...,L.
- R6: The stride of the next line (with the same L) is the address produced at index (L>>1)+1 of the current line. For L=11, the second line is 0 6 1 7 2 8 3 9 4 10 5 11.
- R7: While `addr_vld_o` is high and `step_i` is low, `addr_o` and `addr_vld_o` hold their values.
- R8: `line_go_i` while a line is active, and `step_i` while idle, have no effect: the line in progress continues unchanged, and no address is presented while idle.
- R9: For L=11 with the line length held, line 11 (after ten line transitions) is again 0,1,...,11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| last_idx_i | input | AW | Line length minus one, sampled at line start |
| line_go_i | input | 1 | Line start strobe, honoured only when idle |
| step_i | input | 1 | Consume the presented address |
| addr_o | output | AW | Current buffer address |
| addr_vld_o | output | 1 | Address is valid |

## Verification
The assertions assume that `line_go_i` matters only while idle and that `last_idx_i` is read only at a line start. They also assume the stride never exceeds L, which holds because every captured address is folded into 0..L. The stimulus drives the start strobe only after the previous line has drained. The one exception is a deliberate mid-line strobe that carries a different length, used to show that it is ignored. The stimulus keeps `last_idx_i` steady over each line. Advance holes are inserted on a fixed cycle pattern, so the hold behaviour is exercised while every line still completes.

// File: rtl/pla_pkg.sv
// Shared types for the split-order line address generator.
// Assumes nothing beyond a two-state line phase.
package pla_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/pla_step.sv
// Per-pixel modular step: forms acc+incr and acc+(incr-lim) in parallel and
// picks the folded sum when acc exceeds (lim-incr).
// Assumes acc <= lim and 1 <= incr <= lim; thr and incm are precomputed.
module pla_step #(
    parameter int AW = 12
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] incr_i,
    input  logic [AW-1:0] incm_i,
    input  logic [AW-1:0] thr_i,
    output logic [AW-1:0] nxt_o
);
    logic [AW-1:0] sum_plain;
    logic [AW-1:0] sum_fold;

    // Two parallel adders and a select on the threshold compare.
    always_comb begin
        sum_plain = acc_i + incr_i;
        sum_fold  = acc_i + incm_i;
        nxt_o     = (acc_i > thr_i) ? sum_fold : sum_plain;
    end
endmodule

// File: rtl/pla_stride.sv
// Holds the stride of the running line with its two slow terms, and the
// pending stride for the next line with its terms, prepared at line end.
// Assumes launch_i only when idle, and cap_i/fin_i only while running.
module pla_stride #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [AW-1:0] last_idx_i,
    input  logic          cap_i,
    input  logic [AW-1:0] cap_val_i,
    input  logic          fin_i,
    output logic [AW-1:0] lim_o,
    output logic [AW-1:0] incr_o,
    output logic [AW-1:0] incm_o,
    output logic [AW-1:0] thr_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] lim_q, incr_q, incm_q, thr_q;
    logic [AW-1:0] pinc_q, pdiff_q, pthr_q;
    logic          lim_ok_q;
    logic          keep;

    // Reuse the pending stride only when the length is unchanged.
    always_comb keep = lim_ok_q && (last_idx_i == lim_q);

    // Stride registers: load at launch, capture mid-line, prepare at line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q    <= '0;
            lim_ok_q <= 1'b0;
            incr_q   <= ONE;
            incm_q   <= ONE;
            thr_q    <= '0;
            pinc_q   <= ONE;
            pdiff_q  <= ONE;
            pthr_q   <= '0;
        end else begin
            if (launch_i) begin
                lim_q    <= last_idx_i;
                lim_ok_q <= 1'b1;
                if (keep) begin
                    incr_q <= pinc_q;
                    incm_q <= pdiff_q;
                    thr_q  <= pthr_q;
                end else begin
                    incr_q  <= ONE;
                    incm_q  <= ONE - last_idx_i;
                    thr_q   <= last_idx_i - ONE;
                    pinc_q  <= ONE;
                    pdiff_q <= ONE - last_idx_i;
                    pthr_q  <= last_idx_i - ONE;
                end
            end
            if (cap_i) begin
                pinc_q <= cap_val_i;
            end
            if (fin_i) begin
                pdiff_q <= pinc_q - lim_q;
                pthr_q  <= lim_q - pinc_q;
            end
        end
    end

    always_comb begin
        lim_o  = lim_q;
        incr_o = incr_q;
        incm_o = incm_q;
        thr_o  = thr_q;
    end

    // R5: a fresh or changed length restarts the stride at one.
    p_fresh_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i && !keep |=> incr_q == ONE);
endmodule

// File: rtl/pla_seq.sv
// Line sequencer: pixel counter, address accumulator and line phase.
// Presents lim as the final address and flags the mid-point capture.
// Assumes lim_i is stable while running (it changes only at launch).
module pla_seq
    import pla_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic          step_i,
    input  logic [AW-1:0] lim_i,
    input  logic [AW-1:0] nxt_i,
    output logic          launch_o,
    output logic          cap_o,
    output logic          fin_o,
    output logic [AW-1:0] acc_o,
    output logic [AW-1:0] addr_o,
    output logic          vld_o
);
    phase_e        ph_q;
    logic [AW-1:0] cnt_q;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] mid;
    logic          adv;
    logic          at_end;

    // Decode launch, advance, end of line and mid-point capture.
    always_comb begin
        mid      = lim_i >> 1;
        launch_o = go_i && (ph_q == PH_IDLE);
        adv      = step_i && (ph_q == PH_RUN);
        at_end   = (cnt_q == lim_i);
        fin_o    = adv && at_end;
        cap_o    = adv && !at_end && (cnt_q == mid);
    end

    // Phase, counter and accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            acc_q <= '0;
        end else if (launch_o) begin
            ph_q  <= PH_RUN;
            cnt_q <= '0;
            acc_q <= '0;
        end else if (adv) begin
            if (at_end) begin
                ph_q <= PH_IDLE;
            end else begin
                cnt_q <= cnt_q + AW'(1);
                acc_q <= nxt_i;
            end
        end
    end

    // Output select: the last index closes every line.
    always_comb begin
        acc_o  = acc_q;
        addr_o = at_end ? lim_i : acc_q;
        vld_o  = (ph_q == PH_RUN);
    end

    // R2: every line opens at address zero.
    p_open_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld_o) |-> addr_o == '0);
    // R3: addresses stay within 0..lim.
    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> addr_o <= lim_i);
    // R7: no advance means no change.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o && !step_i |=> vld_o && $stable(addr_o));
    // R4: accepting the final address ends the line.
    p_end_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o && step_i && at_end |=> !vld_o);
    // R8: idle without a start stays idle.
    p_idle_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o && !go_i |=> !vld_o);
endmodule

// File: rtl/perm_line_addr.sv
// Top: split-order address generator for an in-place line buffer.
// Assumes line_go_i matters only while idle; last_idx_i is read at line start.
module perm_line_addr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] last_idx_i,
    input  logic          line_go_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          addr_vld_o
);
    logic          launch, cap, fin;
    logic [AW-1:0] lim, incr, incm, thr, acc, nxt;

    pla_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (line_go_i),
        .step_i   (step_i),
        .lim_i    (lim),
        .nxt_i    (nxt),
        .launch_o (launch),
        .cap_o    (cap),
        .fin_o    (fin),
        .acc_o    (acc),
        .addr_o   (addr_o),
        .vld_o    (addr_vld_o)
    );

    pla_stride #(.AW(AW)) u_stride (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .last_idx_i (last_idx_i),
        .cap_i      (cap),
        .cap_val_i  (nxt),
        .fin_i      (fin),
        .lim_o      (lim),
        .incr_o     (incr),
        .incm_o     (incm),
        .thr_o      (thr)
    );

    pla_step #(.AW(AW)) u_step (
        .acc_i  (acc),
        .incr_i (incr),
        .incm_i (incm),
        .thr_i  (thr),
        .nxt_o  (nxt)
    );

    // R1: no address is presented during or right after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !addr_vld_o);
endmodule

// File: tb/tb_perm_line_addr.sv
module tb_perm_line_addr;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] last_idx_i = '0;
    logic          line_go_i = 1'b0;
    logic          step_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic          addr_vld_o;

    int n_run = 0;
    int n_fail = 0;
    int exp_q[$];
    int rec[$];
    int acc_cnt = 0;
    int m_inc = 1;
    int m_lim = -1;
    bit mon_on = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    perm_line_addr #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .last_idx_i(last_idx_i),
        .line_go_i(line_go_i), .step_i(step_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: R2/R3/R4/R7 address order, holding without advance.
    always @(negedge clk) begin
        if (mon_on && rst_n && addr_vld_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 extra address", int'(addr_o), -1);
            end else begin
                check(int'(addr_o) == exp_q[0], "R3/R7 address", int'(addr_o), exp_q[0]);
                if (step_i) begin
                    rec.push_back(int'(addr_o));
                    void'(exp_q.pop_front());
                    acc_cnt++;
                end
            end
        end
    end

    // Driver: push the modelled sequence, start the line, step with holes.
    task automatic run_line(input int lim, input int pat, input bit poke);
        int a, na, ninc, steps, cyc;
        if (lim != m_lim) m_inc = 1;
        m_lim = lim;
        a = 0;
        ninc = m_inc;
        for (int c = 0; c < lim; c++) begin
            exp_q.push_back(a);
            na = a + m_inc;
            if (na > lim) na = na - lim;
            if (c == (lim >> 1)) ninc = na;
            a = na;
        end
        exp_q.push_back(lim);
        m_inc = ninc;
        rec.delete();
        acc_cnt = 0;
        @(posedge clk); #1;
        last_idx_i = AW'(lim);
        line_go_i = 1'b1;
        @(posedge clk); #1;
        line_go_i = 1'b0;
        steps = 0;
        cyc = 0;
        while (steps < lim + 1) begin
            step_i = (pat == 0) ? 1'b1 : ((cyc % pat) != 0);
            if (poke && cyc == 3) begin
                line_go_i = 1'b1;           // R8: ignored mid-line
                last_idx_i = AW'(lim + 2);
            end else begin
                line_go_i = 1'b0;
            end
            if (step_i) steps++;
            cyc++;
            @(posedge clk); #1;
        end
        line_go_i = 1'b0;
        last_idx_i = AW'(lim);
        step_i = 1'b1;                      // R8: step while idle
        @(posedge clk); #1;
        step_i = 1'b0;
        @(negedge clk);
        check(acc_cnt == lim + 1, "R4 count", acc_cnt, lim + 1);
        check(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
        check(addr_vld_o == 1'b0, "R8 idle step", int'(addr_vld_o), 0);
        exp_q.delete();
    endtask

    task automatic check_ident(input string req, input int lim);
        for (int i = 0; i <= lim; i++)
            check(rec.size() > i && rec[i] == i, req, (rec.size() > i) ? rec[i] : -1, i);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lit[12] = '{0, 6, 1, 7, 2, 8, 3, 9, 4, 10, 5, 11};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;
        // R1: quiet after reset, even with step high.
        step_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(addr_vld_o == 1'b0, "R1 reset idle", int'(addr_vld_o), 0);
        end
        #1 step_i = 1'b0;

        // R5/R6/R9: length 12, ten transitions.
        for (int ln = 1; ln <= 11; ln++) begin
            run_line(11, (ln % 2 == 0) ? 3 : 0, 1'b0);
            if (ln == 1) check_ident("R5 first line", 11);
            if (ln == 2)
                for (int i = 0; i < 12; i++)
                    check(rec[i] == lit[i], "R6 second line", rec[i], lit[i]);
            if (ln == 11) check_ident("R9 identity", 11);
        end
        // R8: mid-line start with another length is ignored.
        run_line(11, 2, 1'b1);
        // R5: new length gives sequential order.
        run_line(15, 0, 1'b0);
        check_ident("R5 new length", 15);
        run_line(15, 2, 1'b0);
        run_line(15, 0, 1'b0);
        run_line(1, 0, 1'b0);
        run_line(1, 3, 1'b0);
        run_line(0, 0, 1'b0);
        run_line(11, 0, 1'b0);
        check_ident("R5 length back", 11);
        run_line(11, 0, 1'b0);
        for (int i = 0; i < 12; i++)
            check(rec[i] == lit[i], "R6 after return", rec[i], lit[i]);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule